// File: doc/BRIEF.md
# Configuration Capability Chain Walker

This engine discovers every capability that one device function advertises in its configuration space. It has a dword-wide read port to that space. After a start pulse it first reads the Status register and checks the capabilities-present flag. If the flag is set, it fetches the first pointer from the capability pointer register and follows the one-byte ID / next-pointer pairs of the classic list. It then walks the extended list, whose header is always at byte offset 0x100 and whose 32-bit headers carry a 16-bit ID, a 4-bit version and a 12-bit next offset. For each capability it finds, it emits one record: byte offset, ID, version, and a flag that says which list the record came from. Classic and extended IDs overlap, so this flag is needed to tell them apart.

The walk ends with a one-cycle `walk_done` pulse, or with a one-cycle `walk_err` pulse when a pointer is malformed or a list is longer than the space it lives in can hold. This entry-count limit keeps a circular list from hanging the engine.

The controller is a five-state machine:
- `S_IDLE` waits for `start`.
- `S_STAT` reads the Status dword. A set flag moves to `S_CPTR`. A clear flag skips to `S_EXT`.
- `S_CPTR` reads the pointer register. A zero pointer goes to `S_EXT`. A pointer below the header goes to `S_IDLE` with an error. Any other pointer goes to `S_CLS`.
- `S_CLS` reads one classic entry per visit. It loops on itself while the chain continues, goes to `S_EXT` on a zero next pointer, and goes to `S_IDLE` with an error on a bad pointer or at the entry limit.
- `S_EXT` reads one extended header per visit. It loops on itself while the chain continues, goes to `S_IDLE` with done on a zero next offset or an empty first header, and goes to `S_IDLE` with an error on a bad offset or at the entry limit.

Top module: `cap_chain_walker`

## Requirements
- R1: After reset, `rd_req`, `rec_valid`, `walk_done` and `walk_err` are all low.
- R2: `start` is acted on only in `S_IDLE`. A start pulse during a walk causes no restart and no extra records, and once the walk ends `rd_req` stays low until the next start.
- R3: The first read is dword 1 (the Status dword). When its bit 20 is clear, no classic record is emitted and the walk goes straight to the extended header at byte 0x100 (dword 64).
- R4: When bit 20 is set, dword 13 is read. Its byte 0, with the low two bits cleared, is the first classic offset. A zero value skips the classic list.
- R5: For a classic entry at offset P, the record carries offset P, ID = byte 0 of the dword zero-extended to 16 bits, version 0 and `rec_ext` = 0. Byte 1, with its low two bits cleared, is the next offset, and zero ends the classic list.
- R6: A nonzero classic pointer (first or next) below 0x40 ends the walk with `walk_err`. No record is emitted for the entry it points at.
- R7: For an extended header at offset P, the record carries offset P, ID = bits 15:0, version = bits 19:16 and `rec_ext` = 1. Bits 31:20, with the low two bits cleared, give the next offset, and zero ends the walk with `walk_done`.
- R8: An all-zero header at 0x100 means the extended list is empty: the walk ends with `walk_done` and no extended record.
- R9: A nonzero extended next offset below 0x100 ends the walk with `walk_err` after the record of the entry that held it.
- R10: The 48th classic entry, or the 960th extended entry, that points onward instead of ending the list ends the walk with `walk_err` after its record.
- R11: Records, `walk_done` and `walk_err` appear one cycle after the `rd_valid` that decided them. The last record and the end pulse share a cycle. `walk_done` and `walk_err` are never high together, and `rd_req` is low in the cycle of either pulse.
- R12: `rd_req` stays high with `rd_addr` unchanged until `rd_valid` is seen. `rd_data` is taken in the cycle `rd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (pulse) |
| rd_req | output | 1 | Read request, held until answered |
| rd_addr | output | 10 | Dword offset being read |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | 32 | Returned dword |
| rec_valid | output | 1 | A capability record is presented |
| rec_off | output | 12 | Byte offset of the capability |
| rec_id | output | 16 | Capability ID |
| rec_ver | output | 4 | Version (extended only, else 0) |
| rec_ext | output | 1 | 1 = extended list, 0 = classic list |
| walk_done | output | 1 | Walk finished normally (pulse) |
| walk_err | output | 1 | Walk aborted (pulse) |

## Verification
The record path and the end-of-walk path fire in the same cycle whenever a walk ends: the final capability record appears alongside `walk_done` or `walk_err`. The bench provokes this with lists that terminate normally, with lists that end on a low pointer, and with self-looping lists that hit the entry limit. The monitor pops the final expected record and judges the end pulse in the same sampled cycle, so it also confirms that the expected queue is exactly empty at that moment. Read latency is varied from zero to three cycles, so the same coincidence is seen both with back-to-back answers and with stalled ones.

// File: rtl/capwalk_pkg.sv
package capwalk_pkg;
    localparam int CFG_BYTES = 4096;
    localparam int DW_AW     = $clog2(CFG_BYTES / 4);
    localparam int PTR_W     = $clog2(CFG_BYTES);

    localparam logic [PTR_W-1:0] EXT_BASE  = PTR_W'(256);
    localparam logic [PTR_W-1:0] CLS_FLOOR = PTR_W'(64);

    localparam logic [DW_AW-1:0] STAT_DW  = DW_AW'(1);
    localparam logic [DW_AW-1:0] CPTR_DW  = DW_AW'(13);
    localparam int               CAPS_BIT = 20;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STAT,
        S_CPTR,
        S_CLS,
        S_EXT
    } walk_state_t;
endpackage

// File: rtl/capwalk_ptr_chk.sv
module capwalk_ptr_chk #(
    parameter int W     = 12,
    parameter int FLOOR = 64
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] aligned,
    output logic         is_end,
    output logic         is_low
);
    assign aligned = {raw[W-1:2], 2'b00};
    assign is_end  = (aligned == '0);
    assign is_low  = !is_end && (aligned < W'(FLOOR));
endmodule

// File: rtl/capwalk_step_ctr.sv
module capwalk_step_ctr #(
    parameter int LIMIT = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == LAST);

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST);
endmodule

// File: rtl/cap_chain_walker.sv
module cap_chain_walker
    import capwalk_pkg::*;
#(
    parameter int CLS_LIMIT = 48,
    parameter int EXT_LIMIT = 960
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             rd_req,
    output logic [DW_AW-1:0] rd_addr,
    input  logic             rd_valid,
    input  logic [31:0]      rd_data,
    output logic             rec_valid,
    output logic [PTR_W-1:0] rec_off,
    output logic [15:0]      rec_id,
    output logic [3:0]       rec_ver,
    output logic             rec_ext,
    output logic             walk_done,
    output logic             walk_err
);
    walk_state_t      st, st_nx;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic emit, emit_ext, fin_ok, fin_err, cls_clr, ext_clr;

    // pointer sanity checks
    logic [PTR_W-1:0] c_raw, c_al, x_al;
    logic             c_end, c_low, x_end, x_low;

    assign c_raw = {4'h0, (st == S_CPTR) ? rd_data[7:0] : rd_data[15:8]};

    capwalk_ptr_chk #(.W(PTR_W), .FLOOR(64)) u_cls_chk (
        .raw(c_raw), .aligned(c_al), .is_end(c_end), .is_low(c_low));
    capwalk_ptr_chk #(.W(PTR_W), .FLOOR(256)) u_ext_chk (
        .raw(rd_data[31:20]), .aligned(x_al), .is_end(x_end), .is_low(x_low));

    // loop protection
    logic cls_last, ext_last, cls_inc, ext_inc;
    assign cls_inc = (st == S_CLS) && rd_valid;
    assign ext_inc = (st == S_EXT) && rd_valid;

    capwalk_step_ctr #(.LIMIT(CLS_LIMIT)) u_cls_ctr (
        .clk(clk), .rst_n(rst_n), .clr(cls_clr), .inc(cls_inc), .at_limit(cls_last));
    capwalk_step_ctr #(.LIMIT(EXT_LIMIT)) u_ext_ctr (
        .clk(clk), .rst_n(rst_n), .clr(ext_clr), .inc(ext_inc), .at_limit(ext_last));

    // next-state and decision logic
    always_comb begin
        st_nx    = st;
        ptr_d    = ptr_q;
        emit     = 1'b0;
        emit_ext = 1'b0;
        fin_ok   = 1'b0;
        fin_err  = 1'b0;
        cls_clr  = 1'b0;
        ext_clr  = 1'b0;
        unique case (st)
            S_IDLE: if (start) st_nx = S_STAT;
            S_STAT: if (rd_valid) begin
                if (rd_data[CAPS_BIT]) begin
                    st_nx = S_CPTR;
                end else begin
                    st_nx = S_EXT; ptr_d = EXT_BASE; ext_clr = 1'b1;
                end
            end
            S_CPTR: if (rd_valid) begin
                if (c_end) begin
                    st_nx = S_EXT; ptr_d = EXT_BASE; ext_clr = 1'b1;
                end else if (c_low) begin
                    st_nx = S_IDLE; fin_err = 1'b1;
                end else begin
                    st_nx = S_CLS; ptr_d = c_al; cls_clr = 1'b1;
                end
            end
            S_CLS: if (rd_valid) begin
                emit = 1'b1;
                if (c_end) begin
                    st_nx = S_EXT; ptr_d = EXT_BASE; ext_clr = 1'b1;
                end else if (c_low || cls_last) begin
                    st_nx = S_IDLE; fin_err = 1'b1;
                end else begin
                    ptr_d = c_al;
                end
            end
            S_EXT: if (rd_valid) begin
                if (ptr_q == EXT_BASE && rd_data == '0) begin
                    st_nx = S_IDLE; fin_ok = 1'b1;
                end else begin
                    emit = 1'b1; emit_ext = 1'b1;
                    if (x_end) begin
                        st_nx = S_IDLE; fin_ok = 1'b1;
                    end else if (x_low || ext_last) begin
                        st_nx = S_IDLE; fin_err = 1'b1;
                    end else begin
                        ptr_d = x_al;
                    end
                end
            end
            default: st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            ptr_q <= '0;
        end else begin
            st    <= st_nx;
            ptr_q <= ptr_d;
        end
    end

    // outputs
    assign rd_req  = (st != S_IDLE);
    assign rd_addr = (st == S_STAT) ? STAT_DW :
                     (st == S_CPTR) ? CPTR_DW : ptr_q[PTR_W-1:2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            rec_off   <= '0;
            rec_id    <= '0;
            rec_ver   <= '0;
            rec_ext   <= 1'b0;
            walk_done <= 1'b0;
            walk_err  <= 1'b0;
        end else begin
            rec_valid <= emit;
            walk_done <= fin_ok;
            walk_err  <= fin_err;
            if (emit) begin
                rec_off <= ptr_q;
                rec_ext <= emit_ext;
                rec_id  <= emit_ext ? rd_data[15:0] : {8'h00, rd_data[7:0]};
                rec_ver <= emit_ext ? rd_data[19:16] : 4'h0;
            end
        end
    end

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
    // R11
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(walk_done && walk_err));
    // R11
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done || walk_err) |-> !rd_req);
    // R6
    cls_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ext) |-> (rec_off >= CLS_FLOOR && rec_off < EXT_BASE && rec_ver == 4'h0));
    // R9
    ext_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_ext) |-> (rec_off >= EXT_BASE && rec_off[1:0] == 2'b00));
endmodule

// File: tb/tb_cap_chain_walker.sv
module tb_cap_chain_walker;
    import capwalk_pkg::*;

    logic clk = 0, rst_n = 0, start = 0, rd_valid = 0;
    logic [31:0] rd_data = '0;
    logic rd_req, rec_valid, rec_ext, walk_done, walk_err;
    logic [9:0] rd_addr;
    logic [11:0] rec_off;
    logic [15:0] rec_id;
    logic [3:0] rec_ver;

    always #5 clk = ~clk;

    cap_chain_walker dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rec_valid(rec_valid), .rec_off(rec_off),
        .rec_id(rec_id), .rec_ver(rec_ver), .rec_ext(rec_ext),
        .walk_done(walk_done), .walk_err(walk_err));

    int errors = 0, checks = 0, lat = 1, wcnt = 0;
    logic [31:0] mem [0:1023];
    logic [32:0] exp_q[$];
    bit exp_err = 0, end_seen = 0;
    string cur_tag = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // read responder
    always @(negedge clk) begin
        if (rst_n && rd_req) begin
            if (wcnt >= lat) begin
                rd_valid = 1'b1;
                rd_data  = mem[rd_addr];
                wcnt     = 0;
            end else begin
                rd_valid = 1'b0;
                wcnt++;
            end
        end else begin
            rd_valid = 1'b0;
            wcnt     = 0;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rec_valid) begin
                logic [32:0] got, e;
                got = {rec_off, rec_id, rec_ver, rec_ext};
                if (exp_q.size() == 0) begin
                    check(0, rec_ext ? "R7" : "R5", "unexpected record", longint'(got), 0);
                end else begin
                    e = exp_q.pop_front();
                    check(got == e, e[0] ? "R7" : "R5", "record", longint'(got), longint'(e));
                end
            end
            if (walk_done || walk_err) begin
                check(walk_err == exp_err, cur_tag, "end kind err", longint'(walk_err), longint'(exp_err));
                check(exp_q.size() == 0, "R11", "records left at end", exp_q.size(), 0);
                end_seen = 1;
            end
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        exp_q.delete();
    endtask

    task automatic add_cls(input logic [7:0] p, input logic [7:0] id, input logic [7:0] nxt);
        mem[p >> 2][15:0] = {nxt, id};
        exp_q.push_back({4'h0, p, 8'h00, id, 4'h0, 1'b0});
    endtask

    task automatic add_ext(input logic [11:0] p, input logic [15:0] id,
                           input logic [3:0] ver, input logic [11:0] nxt);
        mem[p >> 2] = {nxt, ver, id};
        exp_q.push_back({p, id, ver, 1'b1});
    endtask

    task automatic run_walk(input bit want_err, input string tag, input bit poke);
        exp_err  = want_err;
        cur_tag  = tag;
        end_seen = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1;
            @(negedge clk); start = 0;
        end
        wait (end_seen);
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(rd_req == 0 && rec_valid == 0, "R2", "quiet after end", longint'(rd_req), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=timeout expected=end");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rd_req == 0 && rec_valid == 0 && walk_done == 0 && walk_err == 0,
              "R1", "reset outputs", {rd_req, rec_valid, walk_done, walk_err}, 0);
        rst_n = 1;
        @(negedge clk);
        check(rd_req == 0, "R1", "idle after reset", longint'(rd_req), 0);

        // R3 flag clear: classic skipped, R8 empty extended list
        clear_mem(); lat = 1;
        mem[13] = 32'h0000_0040;
        mem[16] = 32'h0000_0005;
        run_walk(0, "R3", 0);

        // R4 masked first pointer, R5 chain, R7 extended with shared ID, R2 poke
        clear_mem(); lat = 2;
        mem[1] = 32'h0010_0000;
        mem[13] = 32'h0000_0043;
        add_cls(8'h40, 8'h01, 8'h61);
        add_cls(8'h60, 8'h10, 8'hA0);
        add_cls(8'hA0, 8'h05, 8'h00);
        add_ext(12'h100, 16'h0001, 4'h1, 12'h200);
        add_ext(12'h200, 16'h0010, 4'h2, 12'h14B);
        add_ext(12'h148, 16'h000B, 4'h3, 12'h000);
        run_walk(0, "R7", 1);

        // R4 zero pointer skips classic list
        clear_mem(); lat = 0;
        mem[1] = 32'h0010_0000;
        mem[13] = 32'h0000_0000;
        add_ext(12'h100, 16'h0002, 4'h1, 12'h000);
        run_walk(0, "R4", 0);

        // R6 first pointer in header
        clear_mem(); lat = 1;
        mem[1] = 32'h0010_0000;
        mem[13] = 32'h0000_0020;
        run_walk(1, "R6", 0);

        // R6 next pointer in header, after a record
        clear_mem(); lat = 0;
        mem[1] = 32'h0010_0000;
        mem[13] = 32'h0000_0040;
        add_cls(8'h40, 8'h09, 8'h3C);
        run_walk(1, "R6", 0);

        // R8 empty extended list after classic entries
        clear_mem(); lat = 1;
        mem[1] = 32'h0010_0000;
        mem[13] = 32'h0000_0080;
        add_cls(8'h80, 8'h11, 8'h00);
        run_walk(0, "R8", 0);

        // R9 extended next below 0x100
        clear_mem(); lat = 3;
        add_ext(12'h100, 16'h0018, 4'h1, 12'h0FC);
        run_walk(1, "R9", 0);

        // R10 classic self loop: 48 records then error
        clear_mem(); lat = 0;
        mem[1] = 32'h0010_0000;
        mem[13] = 32'h0000_0040;
        mem[16] = 32'h0000_4007;
        for (int i = 0; i < 48; i++) exp_q.push_back({12'h040, 16'h0007, 4'h0, 1'b0});
        run_walk(1, "R10", 0);

        // R10 extended self loop: 960 records then error
        clear_mem(); lat = 1;
        mem[64] = {12'h100, 4'h2, 16'h0019};
        for (int i = 0; i < 960; i++) exp_q.push_back({12'h100, 16'h0019, 4'h2, 1'b1});
        run_walk(1, "R10", 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule